// File: doc/BRIEF.md
# Set-Associative LRU Tag Lookup Engine

This block models the tag side of a write-allocate, set-associative cache for profiling. It does not store data. Each request gives a byte address and an access size. The engine looks up the lines that the access touches and returns one hit-or-miss outcome per request. It also keeps running totals of hits and misses.

Inside each set the ways form a recency list, with way 0 holding the most recently used tag. On a hit, the matching tag moves to way 0. On a miss, the new tag is pushed in at way 0 and the tag in the last way is lost.

An access may spill past the end of its line into the following set. In that case both lines are looked up and updated, one per clock, and the request is still reported as one access. The total cache size, the associativity and the line size are parameters. Each must be a power of two.

Top module: `lru_tag_store`

## Requirements
- R1: After reset every tag entry holds zero, both counters read zero, `req_ready` is high and `res_valid` is low. So a first access whose tag field is zero hits.
- R2: Geometry and address decoding:
  - The number of sets is CACHE_BYTES / LINE_BYTES / WAYS.
  - The set index is (addr >> log2(LINE_BYTES)) & (sets-1).
  - The tag is addr >> (log2(LINE_BYTES) + log2(sets)).
  - The last byte of an access is addr + size - 1.
- R3: A hit in way 0 leaves the set unchanged. A hit in way i > 0 moves ways 0..i-1 down by one and places the hit tag in way 0. When more than one way matches, the lowest-numbered matching way counts.
- R4: A miss shifts every way down by one, discards the tag in the last way and writes the new tag into way 0.
- R5: When the first and last byte fall in the same set, a single lookup is made. `res_valid` pulses on the clock edge after acceptance, and `req_ready` stays high.
- R6: When the last byte's set equals (start set + 1) mod sets, the request is handled in two clock edges:
  - The start line is looked up and updated on the accepting edge.
  - The line holding the last byte is looked up and updated on the next edge, using the tag of the last byte, whether or not the first lookup missed.
  - `req_ready` is low for exactly the one cycle in between.
  - A request offered during that cycle is ignored.
- R7: A two-line request is reported as one access. `res_hit` is 1 only when both lookups hit; otherwise exactly one miss is counted.
- R8: A request that starts in the last set and ends in set 0 is treated as a two-line request (R6, R7).
- R9: When the last byte's set is neither the start set nor the next set, the request returns `res_valid` with `res_err`=1 and `res_hit`=0 on the next edge. No tag is changed and neither counter moves.
- R10: For every non-error result, `hit_count` grows by one on a hit and `miss_count` grows by one on a miss, on the same edge that `res_valid` rises.
- R11: With WAYS=1 the engine behaves as a direct-mapped cache: a hit leaves the single entry unchanged, and a miss replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | SIZE_W | Access size in bytes |
| res_valid | output | 1 | One-cycle pulse: result available |
| res_hit | output | 1 | Result is a hit |
| res_err | output | 1 | Access spans more than two consecutive sets |
| hit_count | output | CNT_W | Total hits |
| miss_count | output | CNT_W | Total misses |

## Verification
The same stimulus drives a 4-way instance and a direct-mapped instance of equal set count, so each access shows up both as a recency promotion and as a plain replacement. The directed patterns each target one behaviour:
- Repeated use of the all-zero initial tags.
- Filling one set beyond its associativity, which separates LRU eviction from other replacement orders.
- Re-touching middle ways, which shows whether the shuffle moves only the entries above the hit.
- Straddling accesses with hit/hit, hit/miss and miss/miss outcomes, which separate "both must hit" from "either hit".
- A straddle from the last set into set 0.
- Oversized and zero-size spans that must be rejected.

A long stretch of pseudo-random small accesses, with gaps in `req_valid` and requests offered while the engine is busy, then checks the engine against the bench model on every clock.

// File: rtl/lru_tag_store.sv
`timescale 1ns/1ps
module lru_tag_store #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 256,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 16,
  parameter int SIZE_W      = 6,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_err,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int SETS     = CACHE_BYTES / LINE_BYTES / WAYS;
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int SET_BITS = $clog2(SETS);
  localparam int IDX_W    = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int TAG_W    = ADDR_W - OFF_W - SET_BITS;
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] x;
    x = (a >> OFF_W) & ADDR_W'(SETS - 1);
    return x[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] x;
    x = a >> (OFF_W + SET_BITS);
    return x[TAG_W-1:0];
  endfunction

  logic [TAG_W-1:0] tags [SETS][WAYS];

  logic             busy;
  logic [IDX_W-1:0] pend_set;
  logic [TAG_W-1:0] pend_tag;
  logic             pend_miss;

  logic [ADDR_W-1:0] end_addr;
  logic [IDX_W-1:0]  s_set, e_set, nxt_set, lk_set;
  logic [TAG_W-1:0]  s_tag, e_tag, lk_tag;
  logic              accept, one_line, two_line, lk_en;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign end_addr  = req_addr + ADDR_W'(req_size) - ADDR_W'(1);
  assign s_set     = set_of(req_addr);
  assign e_set     = set_of(end_addr);
  assign s_tag     = tag_of(req_addr);
  assign e_tag     = tag_of(end_addr);
  assign nxt_set   = (s_set + IDX_W'(1)) & IDX_W'(SETS - 1);
  assign one_line  = (s_set == e_set);
  assign two_line  = !one_line && (nxt_set == e_set);

  assign lk_set = busy ? pend_set : s_set;
  assign lk_tag = busy ? pend_tag : s_tag;
  assign lk_en  = busy || (accept && (one_line || two_line));

  logic [WAYS-1:0]  match;
  logic             hit;
  logic [WAY_W-1:0] hit_way, top;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (tags[lk_set][w] == lk_tag);
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  assign top = hit ? hit_way : WAY_W'(WAYS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          tags[s][w] <= '0;
    end else if (lk_en) begin
      tags[lk_set][0] <= lk_tag;
      for (int w = 1; w < WAYS; w++)
        if (w <= int'(top))
          tags[lk_set][w] <= tags[lk_set][w-1];
    end
  end

  logic done, done_hit;
  assign done     = busy || (accept && one_line);
  assign done_hit = busy ? (hit && !pend_miss) : hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend_set   <= '0;
      pend_tag   <= '0;
      pend_miss  <= 1'b0;
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_err    <= 1'b0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_err   <= 1'b0;
      busy      <= 1'b0;
      if (done) begin
        res_valid <= 1'b1;
        res_hit   <= done_hit;
        if (done_hit) hit_count  <= hit_count + CNT_W'(1);
        else          miss_count <= miss_count + CNT_W'(1);
      end else if (accept && two_line) begin
        busy      <= 1'b1;
        pend_set  <= e_set;
        pend_tag  <= e_tag;
        pend_miss <= !hit;
      end else if (accept) begin
        res_valid <= 1'b1;
        res_err   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lru_tag_store_chk.sv
`timescale 1ns/1ps
module lru_tag_store_chk #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 6,
  parameter int CNT_W      = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_err,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] st, en, nx;
  logic              acc, one_l, two_l;
  logic [CNT_W:0]    total;

  assign st    = (req_addr >> OFF_W) & ADDR_W'(SETS - 1);
  assign en    = ((req_addr + ADDR_W'(req_size) - ADDR_W'(1)) >> OFF_W) & ADDR_W'(SETS - 1);
  assign nx    = (st + ADDR_W'(1)) & ADDR_W'(SETS - 1);
  assign acc   = req_valid && req_ready;
  assign one_l = (st == en);
  assign two_l = !one_l && (nx == en);
  assign total = {1'b0, hit_count} + {1'b0, miss_count};

  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (hit_count == '0 && miss_count == '0 && req_ready && !res_valid));

  a_r5_single_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc && one_l |=> res_valid && !res_err && req_ready);

  a_r6_straddle_wait: assert property (@(posedge clk) disable iff (!rst_n)
    acc && two_l |=> !req_ready && !res_valid);

  a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready && res_valid && !res_err);

  a_r9_bad_span: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !one_l && !two_l |=> res_valid && res_err && !res_hit);

  a_r9_err_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> $stable(hit_count) && $stable(miss_count));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_err |-> total == $past(total) + (CNT_W+1)'(1));

  a_r7_hit_count: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> hit_count == $past(hit_count) + CNT_W'(1));
endmodule

bind lru_tag_store lru_tag_store_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
  .LINE_BYTES(LINE_BYTES), .SETS(CACHE_BYTES / LINE_BYTES / WAYS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_size(req_size), .res_valid(res_valid),
  .res_hit(res_hit), .res_err(res_err), .hit_count(hit_count),
  .miss_count(miss_count)
);

// File: tb/lru_tag_store_tb_top.sv
`timescale 1ns/1ps
module lru_tag_store_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [5:0]  req_size = 6'd1;

  logic        rdy [2];
  logic        rv  [2];
  logic        rh  [2];
  logic        re  [2];
  logic [31:0] hc  [2];
  logic [31:0] mc  [2];

  always #2 clk = ~clk;

  lru_tag_store #(.CACHE_BYTES(256), .WAYS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_addr(req_addr), .req_size(req_size), .res_valid(rv[0]),
    .res_hit(rh[0]), .res_err(re[0]), .hit_count(hc[0]), .miss_count(mc[0]));

  lru_tag_store #(.CACHE_BYTES(64), .WAYS(1)) dm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_addr(req_addr), .req_size(req_size), .res_valid(rv[1]),
    .res_hit(rh[1]), .res_err(re[1]), .hit_count(hc[1]), .miss_count(mc[1]));

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  int mtag [2][4][4];
  int mways [2] = '{4, 1};
  bit pend [2];
  bit pend_hit [2];
  int e_hc [2];
  int e_mc [2];

  function automatic bit mlook(int k, int s, int t);
    int pos;
    bit h;
    h = 0;
    pos = mways[k] - 1;
    for (int w = 0; w < mways[k]; w++)
      if (!h && mtag[k][s][w] == t) begin h = 1; pos = w; end
    for (int w = pos; w > 0; w--) mtag[k][s][w] = mtag[k][s][w-1];
    mtag[k][s][0] = t;
    return h;
  endfunction

  task automatic cmp(string tag, string what, int k, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s inst%0d %s: actual %0d expected %0d", tag, k, what, act, exp);
    end
  endtask

  task automatic step(bit v, int a, int sz, string tag);
    bit x_rv [2], x_rh [2], x_re [2];
    req_valid = v;
    req_addr  = a;
    req_size  = 6'(sz);
    for (int k = 0; k < 2; k++) begin
      int s1, s2, t1, t2, ea;
      bit h1, h2;
      x_rv[k] = 0; x_rh[k] = 0; x_re[k] = 0;
      if (pend[k]) begin
        pend[k] = 0;
        x_rv[k] = 1; x_rh[k] = pend_hit[k];
        if (pend_hit[k]) e_hc[k]++; else e_mc[k]++;
      end else if (v) begin
        ea = (a + sz - 1) & 32'hFFFF_FFFF;
        s1 = (a >> 4) & 3;  t1 = a >> 6;
        s2 = (ea >> 4) & 3; t2 = ea >>> 6;
        if (s1 == s2) begin
          h1 = mlook(k, s1, t1);
          x_rv[k] = 1; x_rh[k] = h1;
          if (h1) e_hc[k]++; else e_mc[k]++;
        end else if (((s1 + 1) & 3) == s2) begin
          h1 = mlook(k, s1, t1);
          h2 = mlook(k, s2, t2);
          pend[k] = 1; pend_hit[k] = h1 && h2;
        end else begin
          x_rv[k] = 1; x_re[k] = 1;
        end
      end
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      cmp(tag, "res_valid", k, int'(rv[k]), int'(x_rv[k]));
      if (x_rv[k]) begin
        cmp(tag, "res_hit", k, int'(rh[k]), int'(x_rh[k]));
        cmp(tag, "res_err", k, int'(re[k]), int'(x_re[k]));
      end
      cmp(tag, "req_ready", k, int'(rdy[k]), int'(!pend[k]));
      cmp(tag, "hit_count", k, int'(hc[k]), e_hc[k]);
      cmp(tag, "miss_count", k, int'(mc[k]), e_mc[k]);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    summary();
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      pend[k] = 0; e_hc[k] = 0; e_mc[k] = 0;
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 4; w++) mtag[k][s][w] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: idle state and zero tags hit
    step(0, 0, 1, "R1");
    step(1, 32'h0000, 4, "R1");
    step(1, 32'h0008, 2, "R1");
    // R2: decoding of set and tag
    step(1, 32'h0040, 4, "R2");
    step(1, 32'h0044, 4, "R2");
    step(1, 32'h0050, 1, "R2");
    step(1, 32'h0090, 1, "R2");
    // R4: fill set 2 past associativity, oldest evicted
    for (int t = 1; t <= 5; t++) step(1, t * 64 + 32, 4, "R4");
    step(1, 1 * 64 + 32, 4, "R4");
    step(1, 3 * 64 + 32, 4, "R4");
    // R3: promotion from middle ways in set 3
    for (int t = 1; t <= 3; t++) step(1, t * 64 + 48, 4, "R3");
    step(1, 1 * 64 + 48, 4, "R3");
    step(1, 0 * 64 + 48, 4, "R3");
    step(1, 1 * 64 + 48, 4, "R3");
    step(1, 7 * 64 + 48, 4, "R3");
    step(1, 2 * 64 + 48, 4, "R3");
    step(1, 3 * 64 + 48, 4, "R3");
    // R5: back-to-back single-line accesses
    step(1, 32'h0004, 8, "R5");
    step(1, 32'h0014, 8, "R5");
    // R6 / R7: straddles, hit/hit, hit/miss, miss/miss, busy offer ignored
    step(1, 32'h000E, 4, "R6");
    step(1, 32'h0F00, 4, "R6");
    step(1, 32'h000E, 4, "R7");
    step(0, 0, 1, "R7");
    step(1, 32'h054E, 4, "R7");
    step(0, 0, 1, "R7");
    step(1, 32'h098E, 8, "R7");
    step(1, 32'h0A00, 4, "R6");
    step(1, 32'h0A00, 4, "R6");
    // R8: last set wraps into set 0
    step(1, 32'h003E, 4, "R8");
    step(0, 0, 1, "R8");
    step(1, 32'h0040, 1, "R8");
    step(1, 32'h003E, 4, "R8");
    step(0, 0, 1, "R8");
    // R9: rejected spans leave tags and counters untouched
    step(1, 32'h0000, 40, "R9");
    step(1, 32'h0010, 0, "R9");
    step(1, 32'h0000, 1, "R9");
    // R10 / R11: random traffic, counters and direct-mapped instance
    for (int i = 0; i < 600; i++) begin
      int a, sz;
      a  = int'($urandom_range(0, 1023));
      sz = int'($urandom_range(1, 8));
      step(($urandom_range(0, 3) != 0), a, sz, (i % 2 == 0) ? "R10" : "R11");
    end
    step(0, 0, 1, "R10");
    step(0, 0, 1, "R10");
    summary();
  end
endmodule